// File: doc/BRIEF.md
# Registered Prefix-Carry ALU

This block is an 8-bit arithmetic logic unit with a register on each side. Each clock edge captures two operands and a 3-bit operation code into an input register. The result and a carry flag are registered at the next edge, so a new operation can enter every cycle. The block supports addition, subtraction and five bitwise functions: AND, OR, XOR, NAND and NOR.

Every operation takes the same combinational path. A front stage forms a per-bit generate term and a per-bit half-sum. A Han-Carlson parallel-prefix network turns the generate/propagate pairs into the carry into each bit. A final XOR of half-sum and carry gives each result bit. Subtraction inverts the second operand and injects a carry-in of one, folded into the generate term of bit 0. The bitwise functions place the wanted function in the half-sum and force all generates and the carry-in to zero, so no result multiplexer is needed. The target clock is 200 MHz, with the prefix network as the critical path.

Top module: `hcalu_top`

## Requirements
- R1: While `rst` is high at a rising edge, both the input register and the output register clear. `res_o` and `cout_o` read 0 after that edge. The first output after reset is released is computed from the cleared input register: code 0 with zero operands, which gives 0.
- R2: Inputs sampled at rising edge k set `res_o`/`cout_o` after rising edge k+1. A new operation may be presented every cycle, and each one produces its own result.
- R3: Code 0 (ADD) gives `res_o = (a + b) mod 256`, and `cout_o` is bit 8 of the unsigned sum.
- R4: Code 1 (SUB) gives `res_o = (a - b) mod 256`. `cout_o` is 1 exactly when a >= b unsigned, meaning no borrow.
- R5: Code 2 (AND), code 3 (OR) and code 4 (XOR) give the bitwise function of a and b, with `cout_o` = 0.
- R6: Code 5 (NAND) and code 6 (NOR) give the inverted bitwise function of a and b, with `cout_o` = 0.
- R7: Code 7 is reserved. It gives `res_o` = 0 and `cout_o` = 0 for any operands.
- R8: A carry propagates correctly across all eight bits through the prefix network: 0xFF+0x01 = 0x00 with carry 1, 0x7F+0x01 = 0x80 with carry 0, 0x00-0x01 = 0xFF with carry 0, and 0x80-0x80 = 0x00 with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 NAND, 6 NOR, 7 reserved) |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| res_o | output | 8 | Registered result |
| cout_o | output | 1 | Registered carry-out (no-borrow flag for SUB) |

## Verification
Two things can happen in the same cycle: a new operation is captured into the input register while the previous operation's result loads into the output register. A streaming test provokes this by presenting a different operation and operand pair on every cycle, alternating arithmetic and bitwise codes. Each result is then judged two sampling points after its inputs, so a leaked carry flag or a stale operand shows up as a mismatch. The second overlap is a reset that arrives while an operation is in flight. Its check confirms that neither the pending nor the completed result survives, and that the first post-reset output comes from cleared inputs rather than from the operands already waiting at the port.

// File: rtl/hcalu_pkg.sv
package hcalu_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_NAND = 3'd5,
        OP_NOR  = 3'd6,
        OP_RSV  = 3'd7
    } alu_op_e;

    // Captured request: operation plus both operands
    typedef struct packed {
        alu_op_e           op;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } alu_req_t;

    // Registered response
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cout;
    } alu_rsp_t;

    // Generate / propagate pair for the prefix tree
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Black cell: merge a higher group with the adjacent lower group
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/hcalu_pg.sv
// Front stage: per-bit generate, propagate and half-sum, shaped by the operation.
module hcalu_pg
    import hcalu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   gen,
    output logic [W-1:0]   prop,
    output logic [W-1:0]   half,
    output logic           cin
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = (op == OP_SUB) ? ~b : b;
        gen   = '0;
        prop  = '0;
        half  = '0;
        cin   = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                gen  = a & b_eff;
                prop = a ^ b_eff;
                half = a ^ b_eff;
                cin  = (op == OP_SUB);
            end
            OP_AND:  half = a & b;
            OP_OR:   half = a | b;
            OP_XOR:  half = a ^ b;
            OP_NAND: half = ~(a & b);
            OP_NOR:  half = ~(a | b);
            default: half = '0;
        endcase
    end
endmodule

// File: rtl/hcalu_prefix.sv
// Han-Carlson carry tree. W must be a power of two, at least 2.
// Levels: odd bits merge with the bit below; Kogge-Stone steps among odd bits
// with spans 2, 4, ...; a closing level fills the even bits.
module hcalu_prefix
    import hcalu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic         cin,
    output logic [W-1:0] carry,
    output logic         cout
);
    localparam int unsigned LG = $clog2(W);

    gp_t [W-1:0] cur;
    gp_t [W-1:0] nxt;

    always_comb begin
        for (int i = 0; i < int'(W); i++) begin
            cur[i].g = gen[i];
            cur[i].p = prop[i];
        end
        // carry-in folded into the bit-0 generate term
        cur[0].g = gen[0] | (prop[0] & cin);

        // level 1: odd bits take in the even bit just below
        nxt = cur;
        for (int i = 1; i < int'(W); i += 2)
            nxt[i] = gp_merge(cur[i], cur[i-1]);
        cur = nxt;

        // sparse Kogge-Stone levels on odd bits
        for (int l = 1; l < int'(LG); l++) begin
            nxt = cur;
            for (int i = 1; i < int'(W); i += 2)
                if (i >= (1 << l))
                    nxt[i] = gp_merge(cur[i], cur[i - (1 << l)]);
            cur = nxt;
        end

        // closing level: even bits above 0 take the odd prefix below
        nxt = cur;
        for (int i = 2; i < int'(W); i += 2)
            nxt[i] = gp_merge(cur[i], cur[i-1]);
        cur = nxt;

        carry[0] = cin;
        for (int i = 1; i < int'(W); i++)
            carry[i] = cur[i-1].g;
        cout = cur[W-1].g;
    end
endmodule

// File: rtl/hcalu_sum.sv
// Result bits: half-sum XOR carry into the bit.
module hcalu_sum #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] half,
    input  logic [W-1:0] carry,
    output logic [W-1:0] res
);
    assign res = half ^ carry;
endmodule

// File: rtl/hcalu_top.sv
module hcalu_top
    import hcalu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_W-1:0]     op_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [DATA_W-1:0]   res_o,
    output logic                cout_o
);
    alu_req_t          req_q;
    alu_rsp_t          rsp_d;
    alu_rsp_t          rsp_q;

    logic [DATA_W-1:0] gen;
    logic [DATA_W-1:0] prop;
    logic [DATA_W-1:0] half;
    logic [DATA_W-1:0] carry;
    logic [DATA_W-1:0] sum;
    logic              cin;
    logic              grp_cout;

    // input register
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.op <= alu_op_e'(op_i);
            req_q.a  <= a_i;
            req_q.b  <= b_i;
        end
    end

    hcalu_pg #(.W(DATA_W)) u_pg (
        .op   (req_q.op),
        .a    (req_q.a),
        .b    (req_q.b),
        .gen  (gen),
        .prop (prop),
        .half (half),
        .cin  (cin)
    );

    hcalu_prefix #(.W(DATA_W)) u_prefix (
        .gen   (gen),
        .prop  (prop),
        .cin   (cin),
        .carry (carry),
        .cout  (grp_cout)
    );

    hcalu_sum #(.W(DATA_W)) u_sum (
        .half  (half),
        .carry (carry),
        .res   (sum)
    );

    always_comb begin
        rsp_d.res  = sum;
        rsp_d.cout = op_is_arith(req_q.op) & grp_cout;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign res_o  = rsp_q.res;
    assign cout_o = rsp_q.cout;
endmodule

// File: rtl/hcalu_chk.sv
module hcalu_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op_i,
    input logic [7:0] a_i,
    input logic [7:0] b_i,
    input logic [7:0] res_o,
    input logic       cout_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (res_o == 8'h00 && !cout_o)); // R1

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(op_i, 2) == 3'd0)
        |-> ({cout_o, res_o} == ({1'b0, $past(a_i, 2)} + {1'b0, $past(b_i, 2)}))); // R3

    AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(op_i, 2) == 3'd1)
        |-> (res_o == 8'($past(a_i, 2) - $past(b_i, 2))
             && cout_o == ($past(a_i, 2) >= $past(b_i, 2)))); // R4

    AST_AND_BITS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(op_i, 2) == 3'd2)
        |-> (res_o == ($past(a_i, 2) & $past(b_i, 2)) && !cout_o)); // R5

    AST_XOR_BITS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(op_i, 2) == 3'd4)
        |-> (res_o == ($past(a_i, 2) ^ $past(b_i, 2)) && !cout_o)); // R5

    AST_NOR_BITS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(op_i, 2) == 3'd6)
        |-> (res_o == ~($past(a_i, 2) | $past(b_i, 2)) && !cout_o)); // R6

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(op_i, 2) == 3'd7)
        |-> (res_o == 8'h00 && !cout_o)); // R7
endmodule

bind hcalu_top hcalu_chk u_hcalu_chk (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/test_hcalu_top.sv
`timescale 1ns/1ps
module test_hcalu_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_i = 3'd0;
    logic [7:0] a_i = 8'h00;
    logic [7:0] b_i = 8'h00;
    logic [7:0] res_o;
    logic       cout_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hcalu_top i_hcalu_top (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .res_o(res_o), .cout_o(cout_o)
    );

    // reference: {carry, result}
    function automatic logic [8:0] ref_alu(logic [2:0] op, logic [7:0] a, logic [7:0] b);
        case (op)
            3'd0: return {1'b0, a} + {1'b0, b};
            3'd1: return {1'b0, a} + {1'b0, ~b} + 9'd1;
            3'd2: return {1'b0, a & b};
            3'd3: return {1'b0, a | b};
            3'd4: return {1'b0, a ^ b};
            3'd5: return {1'b0, ~(a & b)};
            3'd6: return {1'b0, ~(a | b)};
            default: return 9'h000;
        endcase
    endfunction

    function automatic string req_of(logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2, 3'd3, 3'd4: return "R5";
            3'd5, 3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, string what, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one op, wait through capture and output edges, sample at negedge
    task automatic run_one(string req, logic [2:0] op, logic [7:0] a, logic [7:0] b);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(req, $sformatf("op%0d a=%h b=%h", op, a, b), {cout_o, res_o}, ref_alu(op, a, b));
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b0; op_i = 3'd0; a_i = 8'hFF; b_i = 8'hFF;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "cleared during flight", {cout_o, res_o}, 9'h000);
        op_i = 3'd6; a_i = 8'h00; b_i = 8'h00;
        @(posedge clk);
        @(negedge clk);
        check("R1", "held in reset", {cout_o, res_o}, 9'h000);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "first output from cleared inputs", {cout_o, res_o}, 9'h000);
        @(posedge clk);
        @(negedge clk);
        check("R2", "NOR after release", {cout_o, res_o}, 9'h0FF);
    endtask

    task automatic t_latency;
        run_one("R2", 3'd2, 8'h00, 8'h00);
        @(negedge clk);
        op_i = 3'd6; a_i = 8'h00; b_i = 8'h00;
        @(posedge clk);
        @(negedge clk);
        check("R2", "not yet updated after capture edge", {cout_o, res_o}, 9'h000);
        @(posedge clk);
        @(negedge clk);
        check("R2", "updated one edge later", {cout_o, res_o}, 9'h0FF);
    endtask

    task automatic t_stream;
        logic [2:0] ops [8] = '{3'd0, 3'd2, 3'd1, 3'd6, 3'd0, 3'd4, 3'd1, 3'd7};
        logic [7:0] as  [8] = '{8'hF0, 8'hF0, 8'h10, 8'h0F, 8'h80, 8'hAA, 8'h05, 8'hFF};
        logic [7:0] bs  [8] = '{8'h20, 8'h3C, 8'h20, 8'h30, 8'h80, 8'h55, 8'h05, 8'hFF};
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k >= 2)
                check("R2", $sformatf("stream item %0d", k-2), {cout_o, res_o},
                      ref_alu(ops[k-2], as[k-2], bs[k-2]));
            if (k < 8) begin
                op_i = ops[k]; a_i = as[k]; b_i = bs[k];
            end
            @(posedge clk);
        end
    endtask

    task automatic t_corners;
        logic [7:0] cv [4] = '{8'h00, 8'hFF, 8'h80, 8'h7F};
        for (int op = 0; op < 7; op++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    run_one(req_of(3'(op)), 3'(op), cv[i], cv[j]);
    endtask

    task automatic t_random;
        for (int op = 0; op < 7; op++)
            for (int n = 0; n < 20; n++)
                run_one(req_of(3'(op)), 3'(op), 8'($urandom), 8'($urandom));
    endtask

    task automatic t_reserved;
        run_one("R7", 3'd7, 8'hFF, 8'hFF);
        run_one("R7", 3'd7, 8'h5A, 8'h33);
    endtask

    task automatic t_carry_chain;
        run_one("R8", 3'd0, 8'hFF, 8'h01);
        check("R8", "FF+01 literal", {cout_o, res_o}, 9'h100);
        run_one("R8", 3'd0, 8'h7F, 8'h01);
        check("R8", "7F+01 literal", {cout_o, res_o}, 9'h080);
        run_one("R8", 3'd1, 8'h00, 8'h01);
        check("R8", "00-01 literal", {cout_o, res_o}, 9'h0FF);
        run_one("R8", 3'd1, 8'h80, 8'h80);
        check("R8", "80-80 literal", {cout_o, res_o}, 9'h100);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        t_reset();
        t_latency();
        t_carry_chain();
        t_stream();
        t_reserved();
        t_corners();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule